// File: doc/BRIEF.md
# ModR/M and SIB Effective Address Generator

This block turns an addressing byte and the bytes that follow it into an effective offset. A decoder pulses `start` with the addressing byte and a flag that selects 16-bit or 32-bit address arithmetic. The block then pulls only the extra bytes that form needs: an optional scale/index/base byte, then a displacement of zero, one, two or four bytes. These arrive on a valid/ready byte stream.

When the form is complete, `done` is high for one cycle. During that cycle the block presents the offset, the count of extra bytes it consumed, a flag that marks the stack segment as the default, and a flag that marks a register operand. The general registers are read on a flat bus in the order EAX, ECX, EDX, EBX, ESP, EBP, ESI, EDI, with index 0 in the least significant 32 bits. In 16-bit mode the low halves of these registers serve as BX, BP, SI and DI. Opcode decoding, segment overrides and the memory access itself are left to neighbouring blocks.

Top module: `eam_top`

## Requirements
- R1: The addressing byte splits into mode (bits 7:6), reg (bits 5:3) and r/m (bits 2:0). Mode 3 consumes no bytes and raises `reg_operand`. It reports offset 0 with `ss_default` low.
- R2: In 16-bit mode, r/m values 0 to 7 select BX+SI, BX+DI, BP+SI, BP+DI, SI, DI, BP and BX. Any BP-based form raises `ss_default`. In 32-bit mode, r/m selects register r/m as base, and EDX never raises `ss_default`.
- R3: A 16-bit offset is the sum of base, index and displacement taken modulo 65536, with the upper 16 output bits zero.
- R4: Mode 1 adds a sign-extended 8-bit displacement. Mode 2 adds a 16-bit displacement in 16-bit mode and a 32-bit displacement in 32-bit mode. A 32-bit r/m of 5 with mode 1 or 2 uses EBP and raises `ss_default`.
- R5: Mode 0 with 16-bit r/m 6 is a direct 16-bit displacement with no base. Mode 0 with 32-bit r/m 5 is a direct 32-bit displacement. Neither form raises `ss_default`.
- R6: In 32-bit mode with r/m 4 and mode below 3, a scale/index/base byte follows the addressing byte. In that byte, bits 7:6 give the shift applied to the index, bits 5:3 the index register (4 = none) and bits 2:0 the base register.
- R7: A base of 5 with mode 0 is replaced by a 32-bit displacement. A base of 5 with another mode uses EBP and raises `ss_default`. A base of 4 (ESP) raises `ss_default`.
- R8: Displacement bytes are assembled little-endian. `bytes_used` equals the number of bytes taken after the addressing byte (0 to 5).
- R9: A byte is consumed only on a cycle with `byte_valid` and `byte_ready` both high. `byte_ready` is low while idle. Gaps in `byte_valid` only delay the result.
- R10: `done` rises in the cycle after the last consumed byte, or in the cycle after `start` when no byte is needed. It lasts one cycle. A `start` while busy is ignored.
- R11: After reset, `busy`, `done` and `byte_ready` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a new address form (taken when idle) |
| modrm | input | 8 | Addressing byte |
| addr32 | input | 1 | 1 = 32-bit address arithmetic |
| gpr_flat | input | 256 | Eight 32-bit general registers, index 0 lowest |
| byte_valid | input | 1 | Stream byte present |
| byte_data | input | 8 | Stream byte |
| byte_ready | output | 1 | Block takes the stream byte this cycle |
| busy | output | 1 | A form is being collected |
| done | output | 1 | Result valid this cycle |
| ea_offset | output | 32 | Effective offset |
| bytes_used | output | 3 | Bytes taken after the addressing byte |
| ss_default | output | 1 | Default segment is the stack segment |
| reg_operand | output | 1 | Operand is a register (mode 3) |

## Verification
The assertions assume that `gpr_flat` stays stable from `start` to `done`, because the registers are not captured. They also assume that the stream byte and `byte_valid` change only between clock edges. The stimulus loads the register bus once before any form begins and drives every input at the falling edge. The stimulus also pulses `start` during a collection and offers bytes while idle, so the claims that such events are ignored are tested against legal but awkward input timing.

// File: rtl/eam_pkg.sv
package eam_pkg;

  localparam int unsigned EAM_REG_W    = 32;
  localparam int unsigned EAM_NUM_REGS = 8;
  localparam int unsigned EAM_BYTE_W   = 8;
  localparam int unsigned EAM_CNT_W    = 3;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SIB  = 2'd1,
    ST_DISP = 2'd2,
    ST_DONE = 2'd3
  } eam_state_e;

  localparam logic [1:0] MD_NODISP = 2'd0;
  localparam logic [1:0] MD_DISP8  = 2'd1;
  localparam logic [1:0] MD_DISPW  = 2'd2;
  localparam logic [1:0] MD_REG    = 2'd3;

  function automatic logic needs_sib(input logic [1:0] md, input logic [2:0] rm,
                                     input logic a32);
    return a32 && (rm == 3'd4) && (md != MD_REG);
  endfunction

  // displacement length known from the addressing byte alone
  function automatic logic [2:0] first_disp_len(input logic [1:0] md,
                                                input logic [2:0] rm,
                                                input logic a32);
    logic [2:0] n;
    n = 3'd0;
    if (!a32) begin
      case (md)
        MD_DISP8:  n = 3'd1;
        MD_DISPW:  n = 3'd2;
        MD_NODISP: n = (rm == 3'd6) ? 3'd2 : 3'd0;
        default:   n = 3'd0;
      endcase
    end else if (rm != 3'd4) begin
      case (md)
        MD_DISP8:  n = 3'd1;
        MD_DISPW:  n = 3'd4;
        MD_NODISP: n = (rm == 3'd5) ? 3'd4 : 3'd0;
        default:   n = 3'd0;
      endcase
    end
    return n;
  endfunction

  // displacement length once the scale/index/base byte is known
  function automatic logic [2:0] sib_disp_len(input logic [1:0] md,
                                              input logic [2:0] base);
    logic [2:0] n;
    case (md)
      MD_DISP8:  n = 3'd1;
      MD_DISPW:  n = 3'd4;
      MD_NODISP: n = (base == 3'd5) ? 3'd4 : 3'd0;
      default:   n = 3'd0;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/eam_collect.sv
module eam_collect
  import eam_pkg::*;
#(
  parameter int unsigned BYTE_W = EAM_BYTE_W,
  parameter int unsigned CNT_W  = EAM_CNT_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [BYTE_W-1:0]   modrm,
  input  logic                addr32,
  input  logic                byte_valid,
  input  logic [BYTE_W-1:0]   byte_data,
  output logic                byte_ready,
  output logic                busy,
  output logic                done,
  output logic [BYTE_W-1:0]   modrm_q,
  output logic                a32_q,
  output logic [BYTE_W-1:0]   sib_q,
  output logic [4*BYTE_W-1:0] disp_q,
  output logic [CNT_W-1:0]    cnt_q
);

  localparam int unsigned DISP_W = 4 * BYTE_W;
  localparam int unsigned LANE_W = $clog2(BYTE_W);

  eam_state_e          st_q, st_d;
  logic [BYTE_W-1:0]   modrm_d, sib_d;
  logic                a32_d;
  logic [DISP_W-1:0]   disp_d;
  logic [CNT_W-1:0]    cnt_d;
  logic [2:0]          dlen_q, dlen_d;
  logic [1:0]          didx_q, didx_d;
  logic                take;
  logic [2:0]          len_first, len_sib;
  logic [LANE_W+1:0]   lane_lsb;

  assign byte_ready = (st_q == ST_SIB) || (st_q == ST_DISP);
  assign take       = byte_ready && byte_valid;
  assign busy       = (st_q != ST_IDLE);
  assign done       = (st_q == ST_DONE);
  assign len_first  = first_disp_len(modrm[7:6], modrm[2:0], addr32);
  assign len_sib    = sib_disp_len(modrm_q[7:6], byte_data[2:0]);
  assign lane_lsb   = {didx_q, {LANE_W{1'b0}}};

  always_comb begin
    st_d    = st_q;
    modrm_d = modrm_q;
    a32_d   = a32_q;
    sib_d   = sib_q;
    disp_d  = disp_q;
    cnt_d   = cnt_q;
    dlen_d  = dlen_q;
    didx_d  = didx_q;
    case (st_q)
      ST_IDLE: begin
        if (start) begin
          modrm_d = modrm;
          a32_d   = addr32;
          sib_d   = '0;
          disp_d  = '0;
          cnt_d   = '0;
          didx_d  = '0;
          dlen_d  = len_first;
          if (modrm[7:6] == MD_REG)                              st_d = ST_DONE;
          else if (needs_sib(modrm[7:6], modrm[2:0], addr32))    st_d = ST_SIB;
          else if (len_first != 3'd0)                            st_d = ST_DISP;
          else                                                   st_d = ST_DONE;
        end
      end
      ST_SIB: begin
        if (take) begin
          sib_d  = byte_data;
          cnt_d  = cnt_q + 1'b1;
          dlen_d = len_sib;
          st_d   = (len_sib != 3'd0) ? ST_DISP : ST_DONE;
        end
      end
      ST_DISP: begin
        if (take) begin
          disp_d[lane_lsb +: BYTE_W] = byte_data;
          cnt_d  = cnt_q + 1'b1;
          didx_d = didx_q + 1'b1;
          if ({1'b0, didx_q} + 3'd1 == dlen_q) st_d = ST_DONE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      modrm_q <= '0;
      a32_q   <= 1'b0;
      sib_q   <= '0;
      disp_q  <= '0;
      cnt_q   <= '0;
      dlen_q  <= '0;
      didx_q  <= '0;
    end else begin
      st_q    <= st_d;
      modrm_q <= modrm_d;
      a32_q   <= a32_d;
      sib_q   <= sib_d;
      disp_q  <= disp_d;
      cnt_q   <= cnt_d;
      dlen_q  <= dlen_d;
      didx_q  <= didx_d;
    end
  end

  a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r10_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(modrm_q));
  a_r9_idle_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !byte_ready);
  a_r8_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cnt_q <= 3'd5));
  a_r9_no_take_no_count: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !(byte_ready && byte_valid)) |=> $stable(cnt_q));

endmodule

// File: rtl/eam_calc16.sv
module eam_calc16
  import eam_pkg::*;
#(
  parameter int unsigned OFF_W = 16
) (
  input  logic [1:0]       md,
  input  logic [2:0]       rm,
  input  logic [OFF_W-1:0] disp,
  input  logic [OFF_W-1:0] rbx,
  input  logic [OFF_W-1:0] rbp,
  input  logic [OFF_W-1:0] rsi,
  input  logic [OFF_W-1:0] rdi,
  output logic [OFF_W-1:0] off,
  output logic             ss
);

  logic [OFF_W-1:0] base_v, idx_v, disp_v;

  always_comb begin
    base_v = '0;
    idx_v  = '0;
    ss     = 1'b0;
    case (rm)
      3'd0: begin base_v = rbx; idx_v = rsi; end
      3'd1: begin base_v = rbx; idx_v = rdi; end
      3'd2: begin base_v = rbp; idx_v = rsi; ss = 1'b1; end
      3'd3: begin base_v = rbp; idx_v = rdi; ss = 1'b1; end
      3'd4: base_v = rsi;
      3'd5: base_v = rdi;
      3'd6: begin
        if (md != MD_NODISP) begin base_v = rbp; ss = 1'b1; end
      end
      default: base_v = rbx;
    endcase
    case (md)
      MD_DISP8: disp_v = {{(OFF_W-8){disp[7]}}, disp[7:0]};
      MD_DISPW: disp_v = disp;
      default:  disp_v = (rm == 3'd6) ? disp : '0;
    endcase
    off = base_v + idx_v + disp_v;
  end

endmodule

// File: rtl/eam_calc32.sv
module eam_calc32
  import eam_pkg::*;
#(
  parameter int unsigned REG_W    = EAM_REG_W,
  parameter int unsigned NUM_REGS = EAM_NUM_REGS
) (
  input  logic [1:0]                     md,
  input  logic [2:0]                     rm,
  input  logic [7:0]                     sib,
  input  logic [REG_W-1:0]               disp,
  input  logic [NUM_REGS-1:0][REG_W-1:0] regs,
  output logic [REG_W-1:0]               off,
  output logic                           ss
);

  logic [2:0]       sb_base, sb_idx;
  logic [1:0]       sb_scale;
  logic             no_base;
  logic [REG_W-1:0] base_v, idx_v, disp_v;

  assign sb_base  = sib[2:0];
  assign sb_idx   = sib[5:3];
  assign sb_scale = sib[7:6];

  always_comb begin
    idx_v = '0;
    if (rm == 3'd4) begin
      no_base = (md == MD_NODISP) && (sb_base == 3'd5);
      base_v  = no_base ? '0 : regs[sb_base];
      if (sb_idx != 3'd4) idx_v = regs[sb_idx] << sb_scale;
      ss      = (sb_base == 3'd4) || ((sb_base == 3'd5) && (md != MD_NODISP));
    end else begin
      no_base = (md == MD_NODISP) && (rm == 3'd5);
      base_v  = no_base ? '0 : regs[rm];
      ss      = (rm == 3'd5) && (md != MD_NODISP);
    end
    case (md)
      MD_DISP8: disp_v = {{(REG_W-8){disp[7]}}, disp[7:0]};
      MD_DISPW: disp_v = disp;
      default:  disp_v = no_base ? disp : '0;
    endcase
    off = base_v + idx_v + disp_v;
  end

endmodule

// File: rtl/eam_top.sv
module eam_top
  import eam_pkg::*;
#(
  parameter int unsigned REG_W    = EAM_REG_W,
  parameter int unsigned NUM_REGS = EAM_NUM_REGS,
  parameter int unsigned BYTE_W   = EAM_BYTE_W,
  parameter int unsigned CNT_W    = EAM_CNT_W
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start,
  input  logic [BYTE_W-1:0]         modrm,
  input  logic                      addr32,
  input  logic [NUM_REGS*REG_W-1:0] gpr_flat,
  input  logic                      byte_valid,
  input  logic [BYTE_W-1:0]         byte_data,
  output logic                      byte_ready,
  output logic                      busy,
  output logic                      done,
  output logic [REG_W-1:0]          ea_offset,
  output logic [CNT_W-1:0]          bytes_used,
  output logic                      ss_default,
  output logic                      reg_operand
);

  localparam int unsigned HALF_W = REG_W / 2;
  localparam int unsigned IX_BX  = 3;
  localparam int unsigned IX_BP  = 5;
  localparam int unsigned IX_SI  = 6;
  localparam int unsigned IX_DI  = 7;

  logic [1:0]                     rst_sync_q;
  logic                           rst_int_n;
  logic [NUM_REGS-1:0][REG_W-1:0] regs;
  logic [BYTE_W-1:0]              modrm_q, sib_q;
  logic                           a32_q;
  logic [4*BYTE_W-1:0]            disp_q;
  logic [HALF_W-1:0]              off16;
  logic [REG_W-1:0]               off32;
  logic                           ss16, ss32;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_unpack
    assign regs[g] = gpr_flat[g*REG_W +: REG_W];
  end

  eam_collect #(.BYTE_W(BYTE_W), .CNT_W(CNT_W)) u_collect (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .start      (start),
    .modrm      (modrm),
    .addr32     (addr32),
    .byte_valid (byte_valid),
    .byte_data  (byte_data),
    .byte_ready (byte_ready),
    .busy       (busy),
    .done       (done),
    .modrm_q    (modrm_q),
    .a32_q      (a32_q),
    .sib_q      (sib_q),
    .disp_q     (disp_q),
    .cnt_q      (bytes_used)
  );

  eam_calc16 #(.OFF_W(HALF_W)) u_calc16 (
    .md   (modrm_q[7:6]),
    .rm   (modrm_q[2:0]),
    .disp (disp_q[HALF_W-1:0]),
    .rbx  (regs[IX_BX][HALF_W-1:0]),
    .rbp  (regs[IX_BP][HALF_W-1:0]),
    .rsi  (regs[IX_SI][HALF_W-1:0]),
    .rdi  (regs[IX_DI][HALF_W-1:0]),
    .off  (off16),
    .ss   (ss16)
  );

  eam_calc32 #(.REG_W(REG_W), .NUM_REGS(NUM_REGS)) u_calc32 (
    .md   (modrm_q[7:6]),
    .rm   (modrm_q[2:0]),
    .sib  (sib_q),
    .disp (disp_q[REG_W-1:0]),
    .regs (regs),
    .off  (off32),
    .ss   (ss32)
  );

  always_comb begin
    reg_operand = (modrm_q[7:6] == MD_REG);
    if (reg_operand) begin
      ea_offset  = '0;
      ss_default = 1'b0;
    end else if (a32_q) begin
      ea_offset  = off32;
      ss_default = ss32;
    end else begin
      ea_offset  = {{(REG_W-HALF_W){1'b0}}, off16};
      ss_default = ss16;
    end
  end

  a_r1_reg_no_bytes: assert property (@(posedge clk) disable iff (!rst_int_n)
    (done && reg_operand) |-> (bytes_used == '0) && !ss_default);
  a_r5_direct16_len: assert property (@(posedge clk) disable iff (!rst_int_n)
    (done && !a32_q && modrm_q == 8'h06) |-> (bytes_used == 3'd2) && !ss_default);
  a_r7_sib_prefix_len: assert property (@(posedge clk) disable iff (!rst_int_n)
    (done && a32_q && modrm_q[2:0] == 3'd4 && !reg_operand) |-> (bytes_used != '0));
  a_r11_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(rst_int_n) |-> !busy && !done);

endmodule

// File: tb/sim_eam_top.sv
module sim_eam_top;

  typedef struct packed {
    logic [7:0]  md;
    logic        a32;
    logic [39:0] bytes;
    logic [2:0]  nb;
    logic [31:0] off;
    logic        ss;
    logic        rg;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VECS [NV] = '{
    '{8'h00, 1'b0, 40'h0,          3'd0, 32'h0000_1345, 1'b0, 1'b0, 4'd3},
    '{8'h01, 1'b0, 40'h0,          3'd0, 32'h0000_F100, 1'b0, 1'b0, 4'd2},
    '{8'h02, 1'b0, 40'h0,          3'd0, 32'h0000_A345, 1'b1, 1'b0, 4'd2},
    '{8'h43, 1'b0, 40'h80,         3'd1, 32'h0000_8080, 1'b1, 1'b0, 4'd4},
    '{8'h06, 1'b0, 40'h1234,       3'd2, 32'h0000_1234, 1'b0, 1'b0, 4'd5},
    '{8'h46, 1'b0, 40'h10,         3'd1, 32'h0000_8010, 1'b1, 1'b0, 4'd2},
    '{8'h87, 1'b0, 40'h2000,       3'd2, 32'h0000_1000, 1'b0, 1'b0, 4'd3},
    '{8'h44, 1'b0, 40'hFF,         3'd1, 32'h0000_2344, 1'b0, 1'b0, 4'd4},
    '{8'hC5, 1'b0, 40'h0,          3'd0, 32'h0000_0000, 1'b0, 1'b1, 4'd1},
    '{8'h00, 1'b1, 40'h0,          3'd0, 32'h1111_0010, 1'b0, 1'b0, 4'd2},
    '{8'h05, 1'b1, 40'h12345678,   3'd4, 32'h1234_5678, 1'b0, 1'b0, 4'd5},
    '{8'h45, 1'b1, 40'hF0,         3'd1, 32'h0000_7FF0, 1'b1, 1'b0, 4'd4},
    '{8'h82, 1'b1, 40'h00010000,   3'd4, 32'h0001_0300, 1'b0, 1'b0, 4'd2},
    '{8'h04, 1'b1, 40'h88,         3'd1, 32'h1111_0020, 1'b0, 1'b0, 4'd6},
    '{8'h04, 1'b1, 40'h24,         3'd1, 32'h0000_7FF0, 1'b1, 1'b0, 4'd7},
    '{8'h04, 1'b1, 40'h00001000CD, 3'd5, 32'h0000_1020, 1'b0, 1'b0, 4'd7},
    '{8'h44, 1'b1, 40'h0175,       3'd2, 32'h0000_C68B, 1'b1, 1'b0, 4'd7},
    '{8'h84, 1'b1, 40'hFFFFFF001F, 3'd5, 32'h0000_F000, 1'b0, 1'b0, 4'd6},
    '{8'hFF, 1'b1, 40'h0,          3'd0, 32'h0000_0000, 1'b0, 1'b1, 4'd1},
    '{8'h86, 1'b0, 40'h9000,       3'd2, 32'h0000_1000, 1'b1, 1'b0, 4'd3}
  };

  // EAX, ECX, EDX, EBX, ESP, EBP, ESI, EDI from low to high
  localparam logic [255:0] GPR = {32'h0000_0100, 32'h0000_2345, 32'h0000_8000,
                                  32'h0000_7FF0, 32'h0000_F000, 32'h0000_0300,
                                  32'h0000_0004, 32'h1111_0010};

  logic        clk, rst_n, start, addr32, byte_valid;
  logic [7:0]  modrm, byte_data;
  logic        byte_ready, busy, done, ss_default, reg_operand;
  logic [31:0] ea_offset;
  logic [2:0]  bytes_used;
  int          checks, fails;
  bit          finished;

  eam_top u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .modrm(modrm), .addr32(addr32),
    .gpr_flat(GPR), .byte_valid(byte_valid), .byte_data(byte_data),
    .byte_ready(byte_ready), .busy(busy), .done(done), .ea_offset(ea_offset),
    .bytes_used(bytes_used), .ss_default(ss_default), .reg_operand(reg_operand)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic string tag_of(input logic [3:0] r);
    case (r)
      4'd1: return "R1";
      4'd2: return "R2";
      4'd3: return "R3";
      4'd4: return "R4";
      4'd5: return "R5";
      4'd6: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // start a form and feed n stream bytes; returns at the falling edge after
  // the last byte was taken (or after start when n is zero)
  task automatic issue(input logic [7:0] m, input logic a32, input logic [39:0] b,
                       input int n, input bit stall);
    @(negedge clk);
    start = 1'b1; modrm = m; addr32 = a32;
    @(posedge clk); @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < n; k++) begin
      if (stall) begin
        byte_valid = 1'b0;
        @(negedge clk);
      end
      byte_valid = 1'b1;
      byte_data  = b[8*k +: 8];
      for (int w = 0; w < 40 && !byte_ready; w++) @(negedge clk);
      @(posedge clk); @(negedge clk);
      byte_valid = 1'b0;
    end
  endtask

  initial begin
    checks = 0; fails = 0; finished = 1'b0;
    rst_n = 1'b0; start = 1'b0; modrm = '0; addr32 = 1'b0;
    byte_valid = 1'b0; byte_data = '0;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !byte_ready, "R11", "idle in reset", {busy, done, byte_ready}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!busy && !done && !byte_ready, "R11", "idle after reset", {busy, done, byte_ready}, 0);

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      v = VECS[i];
      issue(v.md, v.a32, v.bytes, int'(v.nb), (i % 2) == 1);
      chk(done === 1'b1, "R10", "done after last byte", 32'(done), 1);
      chk(ea_offset === v.off, tag_of(v.req), "offset", ea_offset, v.off);
      chk(bytes_used === v.nb, "R8", "bytes used", 32'(bytes_used), 32'(v.nb));
      chk(ss_default === v.ss, tag_of(v.req), "ss flag", 32'(ss_default), 32'(v.ss));
      chk(reg_operand === v.rg, "R1", "reg operand", 32'(reg_operand), 32'(v.rg));
      @(negedge clk);
      chk(done === 1'b0 && busy === 1'b0, "R10", "done one cycle", {done, busy}, 0);
    end

    // R9: bytes offered while idle are not taken
    byte_valid = 1'b1; byte_data = 8'hAA;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(byte_ready === 1'b0, "R9", "ready low while idle", 32'(byte_ready), 0);
    end
    byte_valid = 1'b0;
    issue(8'h06, 1'b0, 40'h5A3C, 2, 1'b0);
    chk(ea_offset === 32'h0000_5A3C, "R9", "idle bytes not consumed", ea_offset, 32'h5A3C);

    // R10: start during collection is ignored
    @(negedge clk);
    start = 1'b1; modrm = 8'h05; addr32 = 1'b1;
    @(posedge clk); @(negedge clk);
    start = 1'b0;
    byte_valid = 1'b1; byte_data = 8'hEF;
    @(posedge clk); @(negedge clk);
    start = 1'b1; modrm = 8'hC0; addr32 = 1'b0; byte_data = 8'hBE;
    @(posedge clk); @(negedge clk);
    start = 1'b0; byte_data = 8'hAD;
    @(posedge clk); @(negedge clk);
    byte_data = 8'hDE;
    @(posedge clk); @(negedge clk);
    byte_valid = 1'b0;
    chk(done === 1'b1 && ea_offset === 32'hDEAD_BEEF, "R10", "busy start ignored",
        ea_offset, 32'hDEADBEEF);
    chk(reg_operand === 1'b0, "R10", "busy start mode kept", 32'(reg_operand), 0);
    @(negedge clk);
    chk(busy === 1'b0 && done === 1'b0, "R10", "no second result", {busy, done}, 0);

    // R11: reset during collection returns to idle
    @(negedge clk);
    start = 1'b1; modrm = 8'h84; addr32 = 1'b1;
    @(posedge clk); @(negedge clk);
    start = 1'b0;
    chk(byte_ready === 1'b1, "R6", "waits for index byte", 32'(byte_ready), 1);
    rst_n = 1'b0;
    #1;
    chk(!busy && !byte_ready && !done, "R11", "reset mid form", {busy, byte_ready, done}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    issue(8'hC1, 1'b1, 40'h0, 0, 1'b0);
    chk(done === 1'b1 && reg_operand === 1'b1, "R1", "works after reset",
        {done, reg_operand}, 3);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL R10 watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule